// File: doc/BRIEF.md
# Alignment-Word Error-Rate Alarm Monitor

This block sits on the receive side of a 2.048 Mbit/s framed link. It counts the frame alignment words that arrive in error during fixed measurement windows and keeps a word-error-rate alarm flag. The flag has hysteresis. A 4-bit code selects the level that raises the alarm, and a 3-bit code selects the level that drops it. Both codes map onto non-linear tables of errored-word counts.

Neither a raise nor a drop takes effect on a single window. The condition has to be met at the close of one window and again at the close of the next window. When a window misses the condition, the confirmation starts over.

The framer supplies four inputs: a strobe for each received alignment word, an error flag for that word, an in-sync flag and a slow tick. A whole window is a parameterised number of ticks. For a 2-second window this is 2000 ticks of 1 ms. Besides the alarm flag, the block gives a one-cycle change pulse that can drive an interrupt.

Top module: `fas_rate_alarm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `alarm_o` and `alarm_chg_o` are 0. Reset also clears the window count and any pending confirmation.
- R2: A word counts as errored only when `fas_stb_i`, `fas_err_i` and `in_sync_i` are all high in the same cycle. Strobes with `fas_err_i` low never count. A window closes on its `WIN_TICKS`-th tick while in sync. The count is then judged and starts again from zero.
- R3: `thr_cfg_i[3:0]` is the raise code. Codes 0 to 8 give a raise level of 16 + 2·code, which is 16 to 32. Codes 9 to 15 give 36 + 4·(code−9), which is 36 to 60. A window meets the raise condition when its count is at least this level.
- R4: `thr_cfg_i[6:4]` is the drop code. Codes 0 to 7 give drop levels of 8, 9, 10, 12, 14, 16, 20 and 24. A window meets the drop condition when its count is at most this level. Code 3 (12 words) is the intended default.
- R5: The alarm rises only after two consecutive windows meet the raise condition. A window that misses the condition discards a pending raise.
- R6: The alarm falls only after two consecutive windows meet the drop condition. A window that misses the condition discards a pending drop.
- R7: When the drop level is larger than the raise level, the drop level is ignored. In that case a window meets the drop condition only when its count is below the raise level.
- R8: `alarm_chg_o` is high for exactly one cycle, and only in the first cycle in which `alarm_o` shows a new value.
- R9: While `in_sync_i` is low, no words are counted, the window count and tick position are cleared, and any pending confirmation is discarded. `alarm_o` keeps its value.
- R10: The window count saturates at 2^CNT_W−1, which is 63 by default. It never wraps within a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fas_stb_i | input | 1 | One-cycle strobe per received alignment word |
| fas_err_i | input | 1 | The strobed alignment word was received in error |
| in_sync_i | input | 1 | The framer holds frame alignment |
| tick_i | input | 1 | Window time-base strobe |
| thr_cfg_i | input | 7 | [3:0] raise code, [6:4] drop code |
| alarm_o | output | 1 | Word-error-rate alarm |
| alarm_chg_o | output | 1 | One-cycle pulse when `alarm_o` changes |

## Verification
Three situations are hard to reach from the ports.

- **Drop level above raise level.** The bench programs a raise level of 16 and a drop level of 24. It then shows that a window of exactly 16 errors does not start a drop, while two windows of 15 errors do.
- **Loss of sync mid-confirmation.** The bench brings the block to a pending raise, or to a pending drop. It then runs half a window of errors and ticks, drops sync, restores it, and checks that one further qualifying window is not enough.
- **Saturation.** The bench sends 70 errors in a window against the 60-word level. A counter that wrapped would fall below that level.

Every stimulus window has an exact number of errored strobes followed by exactly `WIN_TICKS` ticks. This keeps the expected judgement cycle known.

// File: rtl/fasm_pkg.sv
package fasm_pkg;

   // Hysteresis states; bit 1 is the alarm level itself
   typedef enum logic [1:0] {
      ST_CLEAR    = 2'b00,
      ST_SET_PEND = 2'b01,
      ST_ALARM    = 2'b10,
      ST_CLR_PEND = 2'b11
   } hyst_st_e;

   // Raise level: linear steps of 2 up to code 8, steps of 4 from code 9
   function automatic logic [5:0] raise_level(input logic [3:0] code);
      int unsigned c;
      c = int'(code);
      if (c <= 8) return 6'(16 + 2 * c);
      else        return 6'(36 + 4 * (c - 9));
   endfunction

   // Drop level: three segments with steps of 1, 2 and 4
   function automatic logic [5:0] drop_level(input logic [2:0] code);
      int unsigned c;
      c = int'(code);
      if (c <= 2)      return 6'(8 + c);
      else if (c <= 5) return 6'(12 + 2 * (c - 3));
      else             return 6'(20 + 4 * (c - 6));
   endfunction

endpackage

// File: rtl/fasm_win_timer.sv
module fasm_win_timer #(
   parameter int unsigned WIN_TICKS = 2000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   output logic win_end_o
);
   localparam int unsigned TW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);

   logic [TW-1:0] pos_q;

   assign win_end_o = run_i && tick_i && (pos_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
      end else if (!run_i) begin
         pos_q <= '0;
      end else if (tick_i) begin
         if (pos_q == LAST) pos_q <= '0;
         else               pos_q <= pos_q + 1'b1;
      end
   end

   // R2
   win_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_end_o |=> (pos_q == '0));

   // R9
   sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (pos_q == '0));

endmodule

// File: rtl/fasm_err_counter.sv
module fasm_err_counter #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_nxt_o
);
   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   // Running total including the current cycle's word, saturating
   always_comb begin
      cnt_nxt_o = cnt_q;
      if (inc_i && (cnt_q != SAT)) cnt_nxt_o = cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_nxt_o;
   end

   // R10
   sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cnt_q == SAT) && !clr_i) |=> (cnt_q == SAT));

   // R2
   idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/fasm_thr_decode.sv
module fasm_thr_decode #(
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned TABLE_STYLE = 0
) (
   input  logic [3:0]       raise_code_i,
   input  logic [2:0]       drop_code_i,
   output logic [CNT_W-1:0] raise_lvl_o,
   output logic [CNT_W-1:0] drop_lim_o
);
   import fasm_pkg::*;

   logic [5:0] raise6;
   logic [5:0] drop6;

   generate
      if (TABLE_STYLE == 0) begin : g_arith
         assign raise6 = raise_level(raise_code_i);
         assign drop6  = drop_level(drop_code_i);
      end else begin : g_table
         always_comb begin
            case (raise_code_i)
               4'd0:    raise6 = 6'd16;
               4'd1:    raise6 = 6'd18;
               4'd2:    raise6 = 6'd20;
               4'd3:    raise6 = 6'd22;
               4'd4:    raise6 = 6'd24;
               4'd5:    raise6 = 6'd26;
               4'd6:    raise6 = 6'd28;
               4'd7:    raise6 = 6'd30;
               4'd8:    raise6 = 6'd32;
               4'd9:    raise6 = 6'd36;
               4'd10:   raise6 = 6'd40;
               4'd11:   raise6 = 6'd44;
               4'd12:   raise6 = 6'd48;
               4'd13:   raise6 = 6'd52;
               4'd14:   raise6 = 6'd56;
               default: raise6 = 6'd60;
            endcase
            case (drop_code_i)
               3'd0:    drop6 = 6'd8;
               3'd1:    drop6 = 6'd9;
               3'd2:    drop6 = 6'd10;
               3'd3:    drop6 = 6'd12;
               3'd4:    drop6 = 6'd14;
               3'd5:    drop6 = 6'd16;
               3'd6:    drop6 = 6'd20;
               default: drop6 = 6'd24;
            endcase
         end
      end
   endgenerate

   // A drop level above the raise level is replaced by raise level - 1
   always_comb begin
      raise_lvl_o = CNT_W'(raise6);
      if (drop6 > raise6) drop_lim_o = CNT_W'(raise6 - 6'd1);
      else                drop_lim_o = CNT_W'(drop6);
   end

endmodule

// File: rtl/fasm_hyst_fsm.sv
module fasm_hyst_fsm #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   input  logic             win_end_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] raise_lvl_i,
   input  logic [CNT_W-1:0] drop_lim_i,
   output logic             alarm_o,
   output logic             chg_o
);
   import fasm_pkg::*;

   hyst_st_e st_q, st_d;
   logic     chg_q;
   logic     raise_ok, drop_ok;

   assign raise_ok = (cnt_i >= raise_lvl_i);
   assign drop_ok  = (cnt_i <= drop_lim_i);

   always_comb begin
      st_d = st_q;
      if (!sync_i) begin
         if (st_q == ST_SET_PEND) st_d = ST_CLEAR;
         if (st_q == ST_CLR_PEND) st_d = ST_ALARM;
      end else if (win_end_i) begin
         case (st_q)
            ST_CLEAR:    st_d = raise_ok ? ST_SET_PEND : ST_CLEAR;
            ST_SET_PEND: st_d = raise_ok ? ST_ALARM    : ST_CLEAR;
            ST_ALARM:    st_d = drop_ok  ? ST_CLR_PEND : ST_ALARM;
            default:     st_d = drop_ok  ? ST_CLEAR    : ST_ALARM;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_CLEAR;
         chg_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         chg_q <= st_d[1] ^ st_q[1];
      end
   end

   assign alarm_o = st_q[1];
   assign chg_o   = chg_q;

   // R5
   raise_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_o) |-> ($past(st_q) == ST_SET_PEND));

   // R6
   drop_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(alarm_o) |-> ($past(st_q) == ST_CLR_PEND));

   // R9
   sync_drop_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_i |=> ((st_q == ST_CLEAR) || (st_q == ST_ALARM)));

   // R8
   chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_o |=> !chg_o);

endmodule

// File: rtl/fas_rate_alarm.sv
module fas_rate_alarm #(
   parameter int unsigned WIN_TICKS   = 2000,
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned TABLE_STYLE = 0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       fas_stb_i,
   input  logic       fas_err_i,
   input  logic       in_sync_i,
   input  logic       tick_i,
   input  logic [6:0] thr_cfg_i,
   output logic       alarm_o,
   output logic       alarm_chg_o
);
   // Elaboration-time parameter checks
   generate
      if (CNT_W < 6) begin : g_bad_cntw
         $error("CNT_W must hold the largest raise level of 60");
      end
      if (WIN_TICKS < 1) begin : g_bad_win
         $error("WIN_TICKS must be at least 1");
      end
      if (TABLE_STYLE > 1) begin : g_bad_style
         $error("TABLE_STYLE must be 0 or 1");
      end
   endgenerate

   logic             win_end;
   logic             cnt_inc;
   logic             cnt_clr;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] raise_lvl;
   logic [CNT_W-1:0] drop_lim;

   assign cnt_inc = fas_stb_i && fas_err_i && in_sync_i;
   assign cnt_clr = win_end || !in_sync_i;

   fasm_win_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (in_sync_i),
      .tick_i    (tick_i),
      .win_end_o (win_end)
   );

   fasm_err_counter #(.CNT_W(CNT_W)) u_count (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (cnt_inc),
      .clr_i     (cnt_clr),
      .cnt_nxt_o (cnt_nxt)
   );

   fasm_thr_decode #(.CNT_W(CNT_W), .TABLE_STYLE(TABLE_STYLE)) u_thr (
      .raise_code_i (thr_cfg_i[3:0]),
      .drop_code_i  (thr_cfg_i[6:4]),
      .raise_lvl_o  (raise_lvl),
      .drop_lim_o   (drop_lim)
   );

   fasm_hyst_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sync_i      (in_sync_i),
      .win_end_i   (win_end),
      .cnt_i       (cnt_nxt),
      .raise_lvl_i (raise_lvl),
      .drop_lim_i  (drop_lim),
      .alarm_o     (alarm_o),
      .chg_o       (alarm_chg_o)
   );

   // R2
   alarm_at_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_o != $past(alarm_o)) |-> $past(win_end));

   // R8
   chg_marks_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_chg_o |-> (alarm_o != $past(alarm_o)));

   // R7
   drop_below_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_lim < raise_lvl || drop_lim == raise_lvl);

endmodule

// File: tb/fas_rate_alarm_tb_top.sv
module fas_rate_alarm_tb_top;
   localparam int WIN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb = 1'b0, err = 1'b0, sync = 1'b1, tick = 1'b0;
   logic [6:0] cfg = 7'h38;
   logic       alarm, chg;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // bench model
   bit m_alarm = 1'b0, m_pend = 1'b0;
   int raise_tab [16] = '{16,18,20,22,24,26,28,30,32,36,40,44,48,52,56,60};
   int drop_tab  [8]  = '{8,9,10,12,14,16,20,24};

   always #4 clk = ~clk;

   fas_rate_alarm #(.WIN_TICKS(WIN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .fas_stb_i(stb), .fas_err_i(err),
      .in_sync_i(sync), .tick_i(tick), .thr_cfg_i(cfg),
      .alarm_o(alarm), .alarm_chg_o(chg));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Returns whether the model alarm changed
   function automatic bit model_step(input int n);
      int c, rl, dl;
      bit cond, old;
      c = (n > 63) ? 63 : n;
      rl = raise_tab[cfg[3:0]];
      dl = drop_tab[cfg[6:4]];
      if (dl > rl) dl = rl - 1;
      old = m_alarm;
      cond = m_alarm ? (c <= dl) : (c >= rl);
      if (!cond) m_pend = 1'b0;
      else if (m_pend) begin m_alarm = ~m_alarm; m_pend = 1'b0; end
      else m_pend = 1'b1;
      return old != m_alarm;
   endfunction

   task automatic run_window(input int nerr, input int ngood, input string req);
      bit ch;
      for (int i = 0; i < nerr; i++) begin
         @(negedge clk); stb = 1'b1; err = 1'b1;
      end
      for (int i = 0; i < ngood; i++) begin
         @(negedge clk); stb = 1'b1; err = 1'b0;
      end
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk); stb = 1'b0; err = 1'b0; tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0;
      ch = model_step(nerr);
      check({req, " alarm"}, int'(alarm), int'(m_alarm));
      check({req, " R8 change pulse"}, int'(chg), int'(ch));
      if (ch) begin
         @(negedge clk);
         check("R8 pulse width", int'(chg), 0);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 alarm in reset", int'(alarm), 0);
      check("R1 chg in reset", int'(chg), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 alarm after reset", int'(alarm), 0);
      check("R1 chg after reset", int'(chg), 0);
   endtask

   task automatic t_confirm();
      cfg = {3'd3, 4'd8};                 // raise 32, drop 12
      run_window(32, 0, "R5 first window");
      run_window(5, 0, "R5 miss restarts");
      run_window(32, 0, "R5 pending");
      run_window(32, 0, "R5 confirmed");
      run_window(12, 3, "R6 first drop window");
      run_window(13, 0, "R6 miss restarts");
      run_window(12, 0, "R6 pending");
      run_window(12, 0, "R6 confirmed");
   endtask

   task automatic t_raise_codes();
      int codes [4] = '{0, 8, 9, 15};
      foreach (codes[k]) begin
         cfg = {3'd3, 4'(codes[k])};
         run_window(raise_tab[codes[k]] - 1, 0, "R3 below level");
         run_window(raise_tab[codes[k]] - 1, 0, "R3 below level");
         run_window(raise_tab[codes[k]], 0, "R3 at level");
         run_window(raise_tab[codes[k]], 0, "R3 at level");
         run_window(0, 0, "R4 drop");
         run_window(0, 0, "R4 drop");
      end
   endtask

   task automatic t_drop_codes();
      int codes [2] = '{0, 7};
      foreach (codes[k]) begin
         cfg = {3'(codes[k]), 4'd9};      // raise 36
         run_window(40, 0, "R5 raise");
         run_window(40, 0, "R5 raise");
         run_window(drop_tab[codes[k]] + 1, 0, "R4 above drop");
         run_window(drop_tab[codes[k]] + 1, 0, "R4 above drop");
         run_window(drop_tab[codes[k]], 0, "R4 at drop");
         run_window(drop_tab[codes[k]], 0, "R4 at drop");
      end
   endtask

   task automatic t_drop_above_raise();
      cfg = {3'd7, 4'd0};                 // drop 24 > raise 16
      run_window(16, 0, "R7 raise");
      run_window(16, 0, "R7 raise");
      run_window(16, 0, "R7 equal raise no drop");
      run_window(16, 0, "R7 equal raise no drop");
      run_window(24, 0, "R7 drop level ignored");
      run_window(15, 0, "R7 below raise");
      run_window(15, 0, "R7 below raise drops");
   endtask

   task automatic t_good_words();
      cfg = {3'd3, 4'd0};
      run_window(10, 40, "R2 clean words ignored");
      run_window(10, 40, "R2 clean words ignored");
   endtask

   task automatic t_sync_loss();
      cfg = {3'd3, 4'd0};
      run_window(20, 0, "R9 pending raise");
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); stb = 1'b1; err = 1'b1;
      end
      for (int i = 0; i < 2; i++) begin
         @(negedge clk); stb = 1'b0; err = 1'b0; tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0; sync = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); stb = 1'b1; err = 1'b1; tick = (i == 2);
      end
      @(negedge clk); stb = 1'b0; err = 1'b0; tick = 1'b0; sync = 1'b1;
      m_pend = 1'b0;
      check("R9 alarm kept low", int'(alarm), 0);
      run_window(20, 0, "R9 pending dropped");
      run_window(20, 0, "R9 raise after resync");
      run_window(0, 0, "R9 pending drop");
      @(negedge clk); sync = 1'b0;
      repeat (3) @(negedge clk);
      sync = 1'b1;
      m_pend = 1'b0;
      check("R9 alarm kept high", int'(alarm), 1);
      run_window(0, 0, "R9 drop pending dropped");
      run_window(0, 0, "R9 drop after resync");
   endtask

   task automatic t_saturate();
      cfg = {3'd3, 4'd15};                // raise 60
      run_window(70, 0, "R10 saturated count");
      run_window(70, 0, "R10 saturated count");
      run_window(0, 0, "R10 drop");
      run_window(0, 0, "R10 drop");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_confirm();
      t_raise_codes();
      t_drop_codes();
      t_drop_above_raise();
      t_good_words();
      t_sync_loss();
      t_saturate();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule